// File: doc/BRIEF.md
# Programmable Low-Power Mode Sequencer

This block runs a short byte program that software stores in a small command memory. It uses that program to take one processor core into a low-power state and bring it back out. Software fills the command memory through a word-wide register port. It then picks an entry index for the mode it wants and sets an enable bit. Several modes can share the memory, each with its own entry index.

When the core reports that it has executed a wait-for-interrupt instruction, the sequencer steps through the bytes starting at the entry index. Each byte does one of four things:
- drives a set of power-control lines;
- stalls for a programmed number of cycles;
- parks the sequencer until a wake interrupt arrives;
- ends the program.

Ending the program releases the core. A status register shows the current phase, the byte index and a sticky error flag. The error flag is set when a program runs off the end of the command memory.

Top module: `lpm_seq`

## Requirements
- R1: After reset, the power-control lines, `core_release`, the control register and the status register all read zero.
- R2: The control register sits at offset 0x30. Bit 0 is the enable bit and bits 10:4 hold the 7-bit start index. Every other bit of this register reads zero.
- R3: The command memory is eight 32-bit words at offsets 0x80, 0x84, … 0x9C. Command byte n lives in bits [8*(n%4)+7 : 8*(n%4)] of word n/4. Each word reads back what was written.
- R4: While the enable bit is set, a rising edge on `core_wfi` starts execution at the start index. While the enable bit is clear, such an edge has no effect.
- R5: A byte that is not 0x0F and has bits 7 and 6 clear is a drive command. It takes one cycle and copies its low 6 bits onto `pwr_ctl`. The lines then hold that value until another drive command changes it.
- R6: A byte with bit 7 set parks the sequencer in the waiting state, and `pwr_ctl` does not change while it waits. Once `wake_irq` is high, execution resumes at the following byte.
- R7: A byte with bit 6 set and bit 7 clear is a delay command. Its bits 1:0 select byte field k of the delay register, which sits at offset 0x34, resets to 0x3C102800 and is writable. The next command starts 1 + field_k cycles after the delay byte is fetched.
- R8: The byte 0x0F ends the program. The sequencer returns to idle and pulses `core_release` high for exactly one cycle.
- R9: The status register sits at offset 0x0C and is read-only. Bits 1:0 give the phase: 0 is idle, 1 is running before the wake, 2 is waiting, 3 is running after the wake. Bits 14:8 give the current byte index and bit 16 is the error flag.
- R10: A write to the command memory is dropped while the sequencer is not idle. The same write is accepted once the sequencer is idle.
- R11: If the byte index reaches 32 or beyond while a program is running, the sequencer goes to idle without a release pulse and sets the error flag. This includes a start index of 32 or more. The flag stays set until reset.
- R12: The configuration register (0x08), the voltage register (0x1C) and the three data registers (0x40, 0x44, 0x48) are plain 32-bit read/write registers that reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| core_wfi | input | 1 | Core has executed wait-for-interrupt; a rising edge triggers a run |
| wake_irq | input | 1 | Wake interrupt, level sensitive |
| pwr_ctl | output | 6 | Power-control lines set by drive commands |
| core_release | output | 1 | One-cycle pulse when the program ends |

## Verification
Most internal faults show up on `pwr_ctl` or in the status word within a cycle or two of the faulty fetch. Examples are a wrong byte lane, a wrong index increment or a command decoded into the wrong class. A miscounted delay shows up only as a shift in the cycle where the next drive value appears, so that cycle is measured exactly for each delay field. Faults in the error path, in the release pulse and in the write lock only become visible at the end of a run or on a later readback, so those are checked once each run has finished.

// File: rtl/lpm_seq_pkg.sv
package lpm_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ENTRY = 2'd1,
        ST_WAIT  = 2'd2,
        ST_EXIT  = 2'd3
    } seq_state_e;

    typedef enum logic [1:0] {
        K_END   = 2'd0,
        K_WAIT  = 2'd1,
        K_DELAY = 2'd2,
        K_DRIVE = 2'd3
    } cmd_kind_e;

    localparam int          IDX_W       = 7;
    localparam int          DLY_FIELD_W = 8;
    localparam logic [7:0]  END_CODE    = 8'h0F;

    localparam logic [7:0]  OFS_CFG    = 8'h08;
    localparam logic [7:0]  OFS_STATUS = 8'h0C;
    localparam logic [7:0]  OFS_VCTL   = 8'h1C;
    localparam logic [7:0]  OFS_CTL    = 8'h30;
    localparam logic [7:0]  OFS_DLY    = 8'h34;
    localparam logic [7:0]  OFS_DATA   = 8'h40;
    localparam logic [7:0]  OFS_MEM    = 8'h80;
endpackage

// File: rtl/lpm_seq_regs.sv
module lpm_seq_regs
    import lpm_seq_pkg::*;
#(
    parameter int          CMD_WORDS = 8,
    parameter logic [31:0] DLY_RESET = 32'h3C102800
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we_i,
    input  logic [7:0]                 addr_i,
    input  logic [31:0]                wdata_i,
    output logic [31:0]                rdata_o,
    input  logic                       busy_i,
    input  logic [31:0]                status_i,
    output logic                       enable_o,
    output logic [IDX_W-1:0]           start_o,
    output logic [31:0]                dly_o,
    output logic [CMD_WORDS-1:0][31:0] mem_o
);
    localparam int DATA_REGS = 3;

    typedef struct packed {
        logic                       en;
        logic [IDX_W-1:0]           start;
        logic [31:0]                cfg;
        logic [31:0]                vctl;
        logic [31:0]                dly;
        logic [DATA_REGS-1:0][31:0] data;
        logic [CMD_WORDS-1:0][31:0] mem;
    } regs_t;

    regs_t r_d, r_q;

    // next-state: software writes; command words locked while busy
    always_comb begin
        r_d = r_q;
        if (we_i) begin
            if (addr_i == OFS_CTL) begin
                r_d.en    = wdata_i[0];
                r_d.start = wdata_i[10:4];
            end
            if (addr_i == OFS_CFG)  r_d.cfg  = wdata_i;
            if (addr_i == OFS_VCTL) r_d.vctl = wdata_i;
            if (addr_i == OFS_DLY)  r_d.dly  = wdata_i;
            for (int k = 0; k < DATA_REGS; k++) begin
                if (addr_i == OFS_DATA + 8'(4 * k)) r_d.data[k] = wdata_i;
            end
            if (!busy_i) begin
                for (int i = 0; i < CMD_WORDS; i++) begin
                    if (addr_i == OFS_MEM + 8'(4 * i)) r_d.mem[i] = wdata_i;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.dly <= DLY_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    // read mux
    always_comb begin
        rdata_o = '0;
        if (addr_i == OFS_CTL)    rdata_o = {21'b0, r_q.start, 3'b0, r_q.en};
        if (addr_i == OFS_CFG)    rdata_o = r_q.cfg;
        if (addr_i == OFS_VCTL)   rdata_o = r_q.vctl;
        if (addr_i == OFS_DLY)    rdata_o = r_q.dly;
        if (addr_i == OFS_STATUS) rdata_o = status_i;
        for (int k = 0; k < DATA_REGS; k++) begin
            if (addr_i == OFS_DATA + 8'(4 * k)) rdata_o = r_q.data[k];
        end
        for (int i = 0; i < CMD_WORDS; i++) begin
            if (addr_i == OFS_MEM + 8'(4 * i)) rdata_o = r_q.mem[i];
        end
    end

    assign enable_o = r_q.en;
    assign start_o  = r_q.start;
    assign dly_o    = r_q.dly;
    assign mem_o    = r_q.mem;

    assert_mem_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> $stable(r_q.mem));

    assert_start_tracks_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i == OFS_CTL) |=> (r_q.start == $past(wdata_i[10:4])));
endmodule

// File: rtl/lpm_seq_decode.sv
module lpm_seq_decode
    import lpm_seq_pkg::*;
#(
    parameter int CMD_WORDS = 8,
    parameter int PWR_W     = 6
) (
    input  logic [CMD_WORDS-1:0][31:0] mem_i,
    input  logic [IDX_W-1:0]           ptr_i,
    output logic                       in_range_o,
    output cmd_kind_e                  kind_o,
    output logic [1:0]                 dly_sel_o,
    output logic [PWR_W-1:0]           arg_o
);
    localparam int BYTES  = CMD_WORDS * 4;
    localparam int BSEL_W = $clog2(BYTES);

    logic [7:0] bytes [BYTES];
    logic [7:0] cur;

    // little-endian byte lanes inside each command word
    for (genvar w = 0; w < CMD_WORDS; w++) begin : g_word
        for (genvar b = 0; b < 4; b++) begin : g_lane
            assign bytes[w*4+b] = mem_i[w][8*b +: 8];
        end
    end

    always_comb begin
        in_range_o = (int'(ptr_i) < BYTES);
        cur        = in_range_o ? bytes[ptr_i[BSEL_W-1:0]] : 8'h00;
        if (cur == END_CODE)  kind_o = K_END;
        else if (cur[7])      kind_o = K_WAIT;
        else if (cur[6])      kind_o = K_DELAY;
        else                  kind_o = K_DRIVE;
        dly_sel_o = cur[1:0];
        arg_o     = cur[PWR_W-1:0];
    end
endmodule

// File: rtl/lpm_seq_core.sv
module lpm_seq_core
    import lpm_seq_pkg::*;
#(
    parameter int PWR_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic [IDX_W-1:0] start_i,
    input  logic [31:0]      dly_i,
    input  logic             in_range_i,
    input  cmd_kind_e        kind_i,
    input  logic [1:0]       dly_sel_i,
    input  logic [PWR_W-1:0] arg_i,
    input  logic             core_wfi_i,
    input  logic             wake_i,
    output seq_state_e       state_o,
    output logic [IDX_W-1:0] ptr_o,
    output logic             err_o,
    output logic [PWR_W-1:0] pwr_o,
    output logic             release_o
);
    typedef struct packed {
        seq_state_e             st;
        logic [IDX_W-1:0]       ptr;
        logic [DLY_FIELD_W-1:0] dly;
        logic [PWR_W-1:0]       pwr;
        logic                   rel;
        logic                   err;
        logic                   wfi;
    } core_t;

    core_t c_d, c_q;
    logic [DLY_FIELD_W-1:0] field;

    assign field = dly_i[DLY_FIELD_W*dly_sel_i +: DLY_FIELD_W];

    always_comb begin
        c_d     = c_q;
        c_d.rel = 1'b0;
        c_d.wfi = core_wfi_i;
        unique case (c_q.st)
            ST_IDLE: begin
                if (enable_i && core_wfi_i && !c_q.wfi) begin
                    c_d.st  = ST_ENTRY;
                    c_d.ptr = start_i;
                    c_d.dly = '0;
                end
            end
            ST_WAIT: begin
                if (wake_i) c_d.st = ST_EXIT;
            end
            default: begin
                if (c_q.dly != '0) begin
                    c_d.dly = c_q.dly - DLY_FIELD_W'(1);
                end else if (!in_range_i) begin
                    c_d.st  = ST_IDLE;
                    c_d.err = 1'b1;
                end else begin
                    unique case (kind_i)
                        K_END: begin
                            c_d.st  = ST_IDLE;
                            c_d.rel = 1'b1;
                        end
                        K_WAIT: begin
                            c_d.st  = ST_WAIT;
                            c_d.ptr = c_q.ptr + IDX_W'(1);
                        end
                        K_DELAY: begin
                            c_d.dly = field;
                            c_d.ptr = c_q.ptr + IDX_W'(1);
                        end
                        default: begin
                            c_d.pwr = arg_i;
                            c_d.ptr = c_q.ptr + IDX_W'(1);
                        end
                    endcase
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign state_o   = c_q.st;
    assign ptr_o     = c_q.ptr;
    assign err_o     = c_q.err;
    assign pwr_o     = c_q.pwr;
    assign release_o = c_q.rel;

    assert_release_in_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.rel |-> (c_q.st == ST_IDLE));
    assert_release_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.rel |=> !c_q.rel);
    assert_wait_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_WAIT && !wake_i) |=> (c_q.st == ST_WAIT));
    assert_pwr_frozen_in_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_WAIT) |=> $stable(c_q.pwr));
    assert_error_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.err |=> c_q.err);
    assert_disabled_stays_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_IDLE && !enable_i) |=> (c_q.st == ST_IDLE));
endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
    import lpm_seq_pkg::*;
#(
    parameter int          CMD_WORDS = 8,
    parameter int          PWR_W     = 6,
    parameter logic [31:0] DLY_RESET = 32'h3C102800
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [7:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic             core_wfi,
    input  logic             wake_irq,
    output logic [PWR_W-1:0] pwr_ctl,
    output logic             core_release
);
    logic                       enable;
    logic [IDX_W-1:0]           start_idx;
    logic [31:0]                dly_word;
    logic [CMD_WORDS-1:0][31:0] mem;
    logic [31:0]                status;
    logic                       busy;
    logic                       in_range;
    cmd_kind_e                  kind;
    logic [1:0]                 dly_sel;
    logic [PWR_W-1:0]           arg;
    seq_state_e                 state;
    logic [IDX_W-1:0]           ptr;
    logic                       err;

    always_comb begin
        status        = '0;
        status[1:0]   = state;
        status[14:8]  = ptr;
        status[16]    = err;
    end

    assign busy = (state != ST_IDLE);

    lpm_seq_regs #(.CMD_WORDS(CMD_WORDS), .DLY_RESET(DLY_RESET)) i_regs (
        .clk(clk), .rst_n(rst_n), .we_i(reg_we), .addr_i(reg_addr),
        .wdata_i(reg_wdata), .rdata_o(reg_rdata), .busy_i(busy),
        .status_i(status), .enable_o(enable), .start_o(start_idx),
        .dly_o(dly_word), .mem_o(mem)
    );

    lpm_seq_decode #(.CMD_WORDS(CMD_WORDS), .PWR_W(PWR_W)) i_decode (
        .mem_i(mem), .ptr_i(ptr), .in_range_o(in_range), .kind_o(kind),
        .dly_sel_o(dly_sel), .arg_o(arg)
    );

    lpm_seq_core #(.PWR_W(PWR_W)) i_core (
        .clk(clk), .rst_n(rst_n), .enable_i(enable), .start_i(start_idx),
        .dly_i(dly_word), .in_range_i(in_range), .kind_i(kind),
        .dly_sel_i(dly_sel), .arg_i(arg), .core_wfi_i(core_wfi),
        .wake_i(wake_irq), .state_o(state), .ptr_o(ptr), .err_o(err),
        .pwr_o(pwr_ctl), .release_o(core_release)
    );
endmodule

// File: tb/test_lpm_seq.sv
module test_lpm_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        core_wfi = 1'b0;
    logic        wake_irq = 1'b0;
    logic [5:0]  pwr_ctl;
    logic        core_release;

    int checks = 0;
    int fails  = 0;
    int rel_cnt = 0;

    always #2 clk = ~clk;

    lpm_seq i_lpm_seq (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .core_wfi(core_wfi),
        .wake_irq(wake_irq), .pwr_ctl(pwr_ctl), .core_release(core_release)
    );

    always @(negedge clk) if (core_release) rel_cnt++;

    typedef struct packed {
        logic [31:0] w0, w1, w2, w3;
        logic [6:0]  start;
        logic [5:0]  wpwr;
        logic [6:0]  widx;
        logic [5:0]  epwr;
    } row_t;

    localparam row_t ROWS [4] = '{
        '{32'h0F008001, 32'h0, 32'h0, 32'h0, 7'd0, 6'h01, 7'd2, 6'h00},
        '{32'h0F008001, 32'h02800703, 32'h0000000F, 32'h0, 7'd4, 6'h07, 7'd7, 6'h02},
        '{32'h0, 32'h0, 32'h40C03F41, 32'h00000F10, 7'd8, 6'h3F, 7'd11, 6'h10},
        '{32'h81098008, 32'h00000F0A, 32'h0, 32'h0, 7'd0, 6'h08, 7'd2, 6'h0A}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        core_wfi = 1'b0;
        wake_irq = 1'b0;
        reg_we = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic pulse_wfi();
        @(negedge clk); core_wfi = 1'b1;
        @(negedge clk); core_wfi = 1'b0;
    endtask

    task automatic pulse_wake();
        @(negedge clk); wake_irq = 1'b1;
        @(negedge clk); wake_irq = 1'b0;
    endtask

    task automatic poll_state(input logic [1:0] st, output logic [31:0] s);
        for (int i = 0; i < 300; i++) begin
            rd(8'h0C, s);
            if (s[1:0] == st) break;
        end
    endtask

    // measures cycles from the wfi trigger edge to pwr_ctl == 5
    task automatic dly_timing(input logic [1:0] sel, input logic setdly,
                              input logic [31:0] dval, input int expc);
        int cnt;
        do_reset();
        if (setdly) wr(8'h34, dval);
        wr(8'h80, 32'h000F0500 | {24'h0, 6'b010000, sel});
        wr(8'h30, 32'h1);
        @(negedge clk); core_wfi = 1'b1;
        cnt = 0;
        for (int i = 0; i < 200; i++) begin
            @(posedge clk); @(negedge clk);
            core_wfi = 1'b0;
            cnt++;
            if (pwr_ctl == 6'h05) break;
        end
        chk("R7 delay timing", cnt, expc);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] s;
        int r0;

        do_reset();
        rd(8'h0C, v); chk("R1 status at reset", v, 32'h0);
        chk("R1 pwr at reset", {26'h0, pwr_ctl}, 32'h0);
        chk("R1 release at reset", {31'h0, core_release}, 32'h0);
        rd(8'h30, v); chk("R1 ctl at reset", v, 32'h0);
        rd(8'h34, v); chk("R7 delay reset", v, 32'h3C102800);

        // R12 plain storage
        wr(8'h08, 32'hA5A50001); rd(8'h08, v); chk("R12 cfg", v, 32'hA5A50001);
        wr(8'h1C, 32'h12345678); rd(8'h1C, v); chk("R12 vctl", v, 32'h12345678);
        wr(8'h48, 32'hCAFEF00D); rd(8'h48, v); chk("R12 data2", v, 32'hCAFEF00D);
        rd(8'h40, v); chk("R12 data0 untouched", v, 32'h0);

        // R2 reserved bits
        wr(8'h30, 32'hFFFFFFFF); rd(8'h30, v); chk("R2 ctl fields", v, 32'h000007F1);
        wr(8'h30, 32'h0);

        // R4 disabled trigger ignored, then enabled trigger runs
        wr(8'h80, 32'h00000F11);
        r0 = rel_cnt;
        pulse_wfi();
        repeat (5) @(negedge clk);
        rd(8'h0C, v); chk("R4 disabled status idle", v, 32'h0);
        chk("R4 disabled pwr untouched", {26'h0, pwr_ctl}, 32'h0);
        chk("R4 disabled no release", rel_cnt - r0, 0);
        wr(8'h30, 32'h1);
        pulse_wfi();
        repeat (5) @(negedge clk);
        chk("R4 enabled run drives", {26'h0, pwr_ctl}, 32'h11);
        chk("R8 enabled run releases once", rel_cnt - r0, 1);

        // vector table walk
        foreach (ROWS[r]) begin
            wr(8'h30, 32'h0);
            for (int i = 0; i < 8; i++) begin
                logic [31:0] w;
                case (i)
                    0: w = ROWS[r].w0;
                    1: w = ROWS[r].w1;
                    2: w = ROWS[r].w2;
                    3: w = ROWS[r].w3;
                    default: w = 32'h0;
                endcase
                wr(8'h80 + 8'(4 * i), w);
            end
            rd(8'h80, v); chk("R3 word0 readback", v, ROWS[r].w0);
            rd(8'h84, v); chk("R3 word1 readback", v, ROWS[r].w1);
            rd(8'h88, v); chk("R3 word2 readback", v, ROWS[r].w2);
            wr(8'h30, {21'h0, ROWS[r].start, 4'h1});
            r0 = rel_cnt;
            pulse_wfi();
            poll_state(2'd2, s);
            chk("R6 reached wait", {30'h0, s[1:0]}, 32'd2);
            chk("R5 pwr at wait", {26'h0, pwr_ctl}, {26'h0, ROWS[r].wpwr});
            chk("R9 index at wait", {25'h0, s[14:8]}, {25'h0, ROWS[r].widx});
            for (int i = 0; i < 400; i++) begin
                rd(8'h0C, s);
                if (s[1:0] == 2'd2) pulse_wake();
                else if (s[1:0] == 2'd0) break;
            end
            chk("R8 one release", rel_cnt - r0, 1);
            chk("R5 pwr at end", {26'h0, pwr_ctl}, {26'h0, ROWS[r].epwr});
            chk("R11 no error", {31'h0, s[16]}, 32'h0);
        end

        // R7 exact delay timing per field
        dly_timing(2'd0, 1'b0, 32'h0, 3);
        dly_timing(2'd1, 1'b0, 32'h0, 43);
        dly_timing(2'd2, 1'b0, 32'h0, 19);
        dly_timing(2'd3, 1'b0, 32'h0, 63);
        dly_timing(2'd0, 1'b1, 32'h00000007, 10);

        // R9 phases and R10 write lock
        do_reset();
        wr(8'h80, 32'h0F438043);
        wr(8'h30, 32'h1);
        r0 = rel_cnt;
        pulse_wfi();
        repeat (4) @(negedge clk);
        rd(8'h0C, s); chk("R9 entry phase", {30'h0, s[1:0]}, 32'd1);
        poll_state(2'd2, s);
        chk("R9 wait index", {25'h0, s[14:8]}, 32'd2);
        wr(8'h80, 32'hDEADBEEF);
        rd(8'h80, v); chk("R10 write ignored while busy", v, 32'h0F438043);
        pulse_wake();
        repeat (4) @(negedge clk);
        rd(8'h0C, s); chk("R9 exit phase", {30'h0, s[1:0]}, 32'd3);
        poll_state(2'd0, s);
        chk("R8 release after exit", rel_cnt - r0, 1);
        wr(8'h80, 32'h11223344);
        rd(8'h80, v); chk("R10 write accepted when idle", v, 32'h11223344);

        // R11 overrun
        do_reset();
        wr(8'h9C, 32'h02010000);
        wr(8'h30, {21'h0, 7'd30, 4'h1});
        r0 = rel_cnt;
        pulse_wfi();
        repeat (6) @(negedge clk);
        rd(8'h0C, s); chk("R11 overrun status", s, 32'h00012000);
        chk("R11 overrun pwr", {26'h0, pwr_ctl}, 32'h02);
        wr(8'h30, {21'h0, 7'd40, 4'h1});
        pulse_wfi();
        repeat (4) @(negedge clk);
        rd(8'h0C, s); chk("R11 start beyond memory", s, 32'h00012800);
        chk("R11 no release on error", rel_cnt - r0, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule